// File: doc/BRIEF.md
# Bus Clock Divider for a Two-Wire Serial Controller

This block generates the serial clock (SCL) timing for a two-wire bus controller from the system clock. A configuration word holds two fields. The low field is a prescaler that divides the system clock down to an internal tick rate. The upper field sets how many internal ticks one SCL period lasts: twenty, plus eight per unit of the field, plus a fixed compensation count for rise time, fall time and internal delay.

The bus engine reads a one-cycle pulse at every SCL edge, plus two level indications. One tells it to hold SCL low. The other tells it SCL is released. Each period is split into a low half and a high half. If the cycle count is odd, the extra cycle goes to the low half. The high half is not counted until the bus is seen high, so a target that holds SCL low (clock stretching) simply lengthens the period. A new configuration word is sampled only when a period begins. While disabled, the block idles with both phase indications low.

Top module: `scl_clk_gen`

## Requirements
- R1: During and after reset, with enable low, the edge pulse, the low-phase flag and the high-phase flag are all 0.
- R2: When enable rises while idle, in the next cycle the edge pulse is 1 and the low-phase flag is 1, which starts a period.
- R3: The configuration word carries the prescaler in bits [PRE_W-1:0] and the period field in bits [PRE_W+5:PRE_W].
- R4: One internal tick lasts prescaler+1 system cycles. The low phase lasts ceil(T/2)×(prescaler+1) system cycles, from the falling-edge pulse to the rising-edge pulse.
- R5: The period length T in internal ticks is 20 + 8×period + RND_CYC. The low phase takes ceil(T/2) ticks and the high phase takes floor(T/2) ticks.
- R6: With SCL already high, the time from the rising-edge pulse to the next falling-edge pulse is floor(T/2)×(prescaler+1)+1 system cycles. The extra cycle is the one in which SCL is sampled.
- R7: Each system cycle in which scl_in is sampled low after the rising-edge pulse adds one cycle to the high phase, and the high-phase flag stays 1 during that time.
- R8: A configuration word written in the middle of a period does not change the current period. It governs every period that starts after it.
- R9: Dropping enable returns the block to idle. In the next cycle all three outputs are 0.
- R10: The edge pulse lasts one cycle. The two phase flags are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run the clock generator |
| cfg | input | PRE_W+6 | Prescaler field (low bits) and period field (above it) |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_tick | output | 1 | One-cycle pulse at each SCL edge |
| scl_lo_ph | output | 1 | Engine drives SCL low |
| scl_hi_ph | output | 1 | SCL released, high phase pending or counting |

## Verification
Random prescaler and period pairs cover the whole field range. The measured low and high durations separate an error in the prescaler from an error in the period formula, because the two scale differently. Directed corners use a zero prescaler, the maximum period, and a compensation count that makes the period odd. The odd period shows whether the extra cycle lands in the low half. Random stretch lengths on scl_in show that the high count waits for the line. A word changed in the middle of a period checks that it takes effect at the period boundary. Dropping enable in the middle of a phase checks the return to idle.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HIGH = 2'd3
  } scl_st_e;
endpackage

// File: rtl/scl_cfg_dec.sv
module scl_cfg_dec #(
  parameter int PER_W   = 6,
  parameter int RND_CYC = 3,
  parameter int CW      = 10
) (
  input  logic [PER_W-1:0] per,
  output logic [CW-1:0]    lo_len,
  output logic [CW-1:0]    hi_len
);
  logic [CW-1:0] total;

  always_comb begin
    total  = CW'(20) + (CW'(per) << 3) + CW'(RND_CYC);
    lo_len = (total + CW'(1)) >> 1;
    hi_len = total >> 1;
  end
endmodule

// File: rtl/scl_presc.sv
module scl_presc #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PRE_W-1:0] div,
  output logic             ick
);
  logic [PRE_W-1:0] pc_q, pc_d;

  assign ick = (pc_q == div);

  always_comb begin
    if (clr || ick) pc_d = '0;
    else            pc_d = pc_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  p_pc_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (pc_q <= div) || $changed(div));
endmodule

// File: rtl/scl_phase.sv
module scl_phase
  import scl_div_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ick,
  input  logic          scl_in,
  input  logic [CW-1:0] lo_len,
  input  logic [CW-1:0] hi_len,
  output logic          clr,
  output logic          load,
  output logic          tick,
  output logic          lo_ph,
  output logic          hi_ph
);
  scl_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    load   = 1'b0;
    clr    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        clr = 1'b1;
        if (en) begin
          st_d = ST_LOW; cnt_d = '0; tick_d = 1'b1; load = 1'b1;
        end
      end
      ST_LOW: begin
        if (!en) begin
          st_d = ST_IDLE; clr = 1'b1;
        end else if (ick) begin
          if (cnt_q == lo_len - CW'(1)) begin
            st_d = ST_WAIT; cnt_d = '0; tick_d = 1'b1; clr = 1'b1;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      ST_WAIT: begin
        clr = 1'b1;
        if (!en)         st_d = ST_IDLE;
        else if (scl_in) begin
          st_d = ST_HIGH; cnt_d = '0;
        end
      end
      default: begin
        if (!en) begin
          st_d = ST_IDLE; clr = 1'b1;
        end else if (ick) begin
          if (cnt_q == hi_len - CW'(1)) begin
            st_d = ST_LOW; cnt_d = '0; tick_d = 1'b1; load = 1'b1; clr = 1'b1;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick  = tick_q;
  assign lo_ph = (st_q == ST_LOW);
  assign hi_ph = (st_q == ST_WAIT) || (st_q == ST_HIGH);

  p_tick_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  p_stretch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && en && !scl_in) |=> (st_q == ST_WAIT));
  p_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st_q == ST_IDLE) && !tick);
  p_lo_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOW) |-> (cnt_q < lo_len));
endmodule

// File: rtl/scl_clk_gen.sv
module scl_clk_gen #(
  parameter int PRE_W   = 3,
  parameter int RND_CYC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [PRE_W+5:0]   cfg,
  input  logic               scl_in,
  output logic               scl_tick,
  output logic               scl_lo_ph,
  output logic               scl_hi_ph
);
  localparam int PER_W = 6;
  localparam int MAXT  = 20 + 8 * ((1 << PER_W) - 1) + RND_CYC;
  localparam int CW    = $clog2(MAXT + 1);

  logic [PRE_W-1:0] pre_q;
  logic [PER_W-1:0] per_q;
  logic [CW-1:0]    lo_len, hi_len;
  logic             ick, clr, load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      per_q <= '0;
    end else if (load) begin
      pre_q <= cfg[PRE_W-1:0];
      per_q <= cfg[PRE_W+PER_W-1:PRE_W];
    end
  end

  scl_cfg_dec #(.PER_W(PER_W), .RND_CYC(RND_CYC), .CW(CW)) u_dec (
    .per(per_q), .lo_len(lo_len), .hi_len(hi_len)
  );

  scl_presc #(.PRE_W(PRE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .div(pre_q), .ick(ick)
  );

  scl_phase #(.CW(CW)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(en), .ick(ick), .scl_in(scl_in),
    .lo_len(lo_len), .hi_len(hi_len), .clr(clr), .load(load),
    .tick(scl_tick), .lo_ph(scl_lo_ph), .hi_ph(scl_hi_ph)
  );

  p_phase_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_lo_ph && scl_hi_ph));
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lo_ph && !scl_tick) |-> $stable(per_q) && $stable(pre_q));
endmodule

// File: tb/sim_scl_clk_gen.sv
module sim_scl_clk_gen;
  localparam int PRE_W = 3;
  localparam int RND   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [PRE_W+5:0] cfg = '0;
  logic scl_in = 1'b1;
  logic scl_tick, scl_lo_ph, scl_hi_ph;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scl_clk_gen #(.PRE_W(PRE_W), .RND_CYC(RND)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg(cfg), .scl_in(scl_in),
    .scl_tick(scl_tick), .scl_lo_ph(scl_lo_ph), .scl_hi_ph(scl_hi_ph)
  );

  function automatic int exp_lo(int per, int pre);
    return ((20 + 8 * per + RND + 1) / 2) * (pre + 1);
  endfunction
  function automatic int exp_hi(int per, int pre);
    return ((20 + 8 * per + RND) / 2) * (pre + 1) + 1;
  endfunction

  task automatic chk(string req, int got, int expv);
    n_chk++;
    if (got != expv) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, expv);
    end
  endtask

  // count cycles from the current tick to the next; hold scl_in low for s cycles
  task automatic meas(int s, output int n);
    n = 0;
    if (s > 0) scl_in = 1'b0;
    forever begin
      @(negedge clk);
      n++;
      if (n == s) scl_in = 1'b1;
      if (s > 0 && n <= s && !scl_hi_ph) chk("R7 hi flag during stretch", 0, 1);
      if (scl_tick || n > 20000) break;
    end
    scl_in = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n, pre, per, pre2, per2, s;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 tick in reset", int'(scl_tick), 0);
    chk("R1 lo in reset", int'(scl_lo_ph), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 hi after reset", int'(scl_hi_ph), 0);
    chk("R1 lo after reset", int'(scl_lo_ph), 0);

    for (int i = 0; i < 14; i++) begin
      if (i == 0)      begin pre = 0; per = 0;  end
      else if (i == 1) begin pre = 7; per = 63; end
      else if (i == 2) begin pre = 0; per = 63; end
      else begin pre = int'($urandom % 8); per = int'($urandom % 64); end
      s = int'($urandom % 6);
      en = 1'b0;
      @(negedge clk);
      cfg = {6'(per), 3'(pre)};  // R3 field layout
      en = 1'b1;
      @(negedge clk);
      chk("R2 start tick", int'(scl_tick), 1);
      chk("R2 start lo", int'(scl_lo_ph), 1);
      meas(0, n);
      chk("R4 R5 low length", n, exp_lo(per, pre));
      chk("R10 hi flag after rise", int'(scl_hi_ph && !scl_lo_ph), 1);
      meas(s, n);
      chk("R6 R7 high length", n, exp_hi(per, pre) + s);
      // R8: new word mid-period
      pre2 = int'($urandom % 8); per2 = int'($urandom % 64);
      cfg = {6'(per2), 3'(pre2)};
      meas(0, n);
      chk("R8 old low kept", n, exp_lo(per, pre));
      meas(0, n);
      chk("R8 old high kept", n, exp_hi(per, pre));
      meas(0, n);
      chk("R8 new low applied", n, exp_lo(per2, pre2));
      // R9: drop enable mid high phase
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk("R9 off tick", int'(scl_tick), 0);
      chk("R9 off flags", int'(scl_lo_ph | scl_hi_ph), 0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule